// File: doc/BRIEF.md
# Single-slot recirculating pipeline FIFO

This block is a queue with room for exactly one item. A producer offers an item through an enqueue handshake, a consumer removes it through a dequeue handshake, and the held item is always shown on a data output together with a not-empty flag. A synchronous clear input empties the queue.

The block lets a full slot take a new item in the same cycle that its current item is removed. The result is the same as if the removal happened first. Enqueue readiness therefore depends, within the same cycle, on the dequeue request. A loop that feeds its own output back to its input can then move one item per clock through a single register instead of stalling every other cycle. There is no path from the enqueue data to the output in the same cycle: a new item is visible only from the cycle after it is accepted.

Top module: `pipe_slot_fifo`

## Requirements
- R1: After reset the queue is empty: not_empty_o and deq_ready_o are 0 and enq_ready_o is 1.
- R2: enq_ready_o is 1 when the queue is empty. When the queue is full it equals deq_valid_i in the same cycle.
- R3: deq_ready_o equals not_empty_o. A dequeue request while the queue is empty is ignored, and the queue stays empty unless an enqueue is accepted.
- R4: An item accepted into an empty queue is not shown in the cycle it is accepted. From the next cycle not_empty_o is 1 and first_data_o equals that item.
- R5: A dequeue of a full queue with no enqueue accepted makes the queue empty from the next cycle.
- R6: An enqueue and a dequeue in the same cycle on a full queue keep the queue full. first_data_o shows the old item in that cycle and the new item from the next cycle.
- R7: clr_i empties the queue from the next cycle, including when an enqueue is accepted in the same cycle.
- R8: An enqueue offered to a full queue with no dequeue is refused, and first_data_o keeps its value.
- R9: While the queue is full and neither a dequeue nor a clear occurs, first_data_o and not_empty_o stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear; overrides an enqueue in the same cycle |
| enq_valid_i | input | 1 | Producer offers an item |
| enq_data_i | input | WIDTH | Item offered |
| enq_ready_o | output | 1 | Item is accepted this cycle if offered |
| deq_valid_i | input | 1 | Consumer removes the held item |
| deq_ready_o | output | 1 | A held item can be removed |
| first_data_o | output | WIDTH | Held item; meaningful only while not_empty_o is 1 |
| not_empty_o | output | 1 | Queue holds an item |

## Verification
The assertions assume that inputs are stable around the clock edge and that deq_valid_i may be raised on an empty queue without harm. The bench is built to present this case, not to avoid it. They also assume that enq_data_i carries a defined value whenever enq_valid_i is high. The stimulus changes inputs only on falling edges, always drives defined data, and mixes directed sequences with random requests. The random requests deliberately include dequeues while empty, clears that collide with enqueues, and offers into a full queue.

// File: rtl/psf_pkg.sv
package psf_pkg;

   // Per-cycle decisions made by the handshake logic.
   typedef struct packed {
      logic enq_fire;   // an item is taken in
      logic deq_fire;   // the held item is removed
      logic load;       // slot register captures enq data
      logic nxt_full;   // occupancy after this edge
   } psf_ctl_t;

endpackage

// File: rtl/psf_ctl.sv
module psf_ctl
   import psf_pkg::*;
(
   input  logic     full_q,
   input  logic     clr_i,
   input  logic     enq_valid_i,
   input  logic     deq_valid_i,
   output logic     enq_ready_o,
   output psf_ctl_t ctl_o
);

   logic deq_fire;
   logic enq_fire;

   // A removal only happens when something is held.
   assign deq_fire    = deq_valid_i & full_q;
   // Room exists if empty, or if the held item leaves this cycle.
   assign enq_ready_o = ~full_q | deq_fire;
   assign enq_fire    = enq_valid_i & enq_ready_o;

   always_comb begin
      ctl_o.enq_fire = enq_fire;
      ctl_o.deq_fire = deq_fire;
      ctl_o.load     = enq_fire & ~clr_i;
      if (clr_i)
         ctl_o.nxt_full = 1'b0;
      else if (enq_fire)
         ctl_o.nxt_full = 1'b1;
      else if (deq_fire)
         ctl_o.nxt_full = 1'b0;
      else
         ctl_o.nxt_full = full_q;
   end

endmodule

// File: rtl/psf_flag.sv
module psf_flag (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic nxt_full_i,
   output logic full_q_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         full_q_o <= 1'b0;
      else
         full_q_o <= nxt_full_i;
   end

endmodule

// File: rtl/psf_slot.sv
module psf_slot #(
   parameter int WIDTH = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         q_o <= '0;
      else if (load_i)
         q_o <= d_i;
   end

endmodule

// File: rtl/pipe_slot_fifo.sv
module pipe_slot_fifo
   import psf_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             enq_valid_i,
   input  logic [WIDTH-1:0] enq_data_i,
   output logic             enq_ready_o,
   input  logic             deq_valid_i,
   output logic             deq_ready_o,
   output logic [WIDTH-1:0] first_data_o,
   output logic             not_empty_o
);

   localparam int DataMsb = WIDTH - 1;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("pipe_slot_fifo: WIDTH must be at least 1");
      end
   endgenerate

   logic     full_q;
   psf_ctl_t ctl;

   psf_ctl u_ctl (
      .full_q      (full_q),
      .clr_i       (clr_i),
      .enq_valid_i (enq_valid_i),
      .deq_valid_i (deq_valid_i),
      .enq_ready_o (enq_ready_o),
      .ctl_o       (ctl)
   );

   psf_flag u_flag (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .nxt_full_i (ctl.nxt_full),
      .full_q_o   (full_q)
   );

   psf_slot #(.WIDTH(WIDTH)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (ctl.load),
      .d_i    (enq_data_i[DataMsb:0]),
      .q_o    (first_data_o)
   );

   assign deq_ready_o = full_q;
   assign not_empty_o = full_q;

endmodule

// File: rtl/pipe_slot_fifo_chk.sv
module pipe_slot_fifo_chk #(
   parameter int WIDTH = 32
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             clr_i,
   input logic             enq_valid_i,
   input logic [WIDTH-1:0] enq_data_i,
   input logic             enq_ready_o,
   input logic             deq_valid_i,
   input logic             deq_ready_o,
   input logic [WIDTH-1:0] first_data_o,
   input logic             not_empty_o
);

   always_comb begin
      if (!rst_ni) begin
         assert_reset_empty_R1: assert (!not_empty_o && !deq_ready_o);
      end
   end

   assert_ready_blocked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (not_empty_o && !deq_valid_i) |-> !enq_ready_o);

   assert_ready_open_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!not_empty_o || deq_valid_i) |-> enq_ready_o);

   assert_empty_deq_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!not_empty_o && !enq_valid_i) |=> !not_empty_o);

   assert_fill_visible_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!not_empty_o && enq_valid_i && !clr_i)
      |=> (not_empty_o && first_data_o == $past(enq_data_i)));

   assert_drain_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (not_empty_o && deq_valid_i && !enq_valid_i) |=> !not_empty_o);

   assert_swap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (not_empty_o && deq_valid_i && enq_valid_i && !clr_i)
      |=> (not_empty_o && first_data_o == $past(enq_data_i)));

   assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> !not_empty_o);

   assert_refuse_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (not_empty_o && !deq_valid_i && enq_valid_i && !clr_i)
      |=> $stable(first_data_o));

   assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (not_empty_o && !deq_valid_i && !clr_i)
      |=> (not_empty_o && $stable(first_data_o)));

   assert_ready_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      deq_ready_o == not_empty_o);

endmodule

bind pipe_slot_fifo pipe_slot_fifo_chk #(.WIDTH(WIDTH)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .clr_i        (clr_i),
   .enq_valid_i  (enq_valid_i),
   .enq_data_i   (enq_data_i),
   .enq_ready_o  (enq_ready_o),
   .deq_valid_i  (deq_valid_i),
   .deq_ready_o  (deq_ready_o),
   .first_data_o (first_data_o),
   .not_empty_o  (not_empty_o)
);

// File: tb/sim_pipe_slot_fifo.sv
`timescale 1ns/1ps
module sim_pipe_slot_fifo;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         clr = 1'b0;
   logic         enq_v = 1'b0;
   logic [W-1:0] enq_d = '0;
   logic         deq_v = 1'b0;
   logic         enq_rdy;
   logic         deq_rdy;
   logic [W-1:0] first_d;
   logic         nempty;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] model_q[$];

   always #2.5 clk = ~clk;

   pipe_slot_fifo #(.WIDTH(W)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .clr_i(clr),
      .enq_valid_i(enq_v), .enq_data_i(enq_d), .enq_ready_o(enq_rdy),
      .deq_valid_i(deq_v), .deq_ready_o(deq_rdy),
      .first_data_o(first_d), .not_empty_o(nempty)
   );

   // Behavioural reference: a queue capped at one entry, removal first.
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         model_q.delete();
      end else if (clr) begin
         model_q.delete();
      end else begin
         bit do_deq;
         bit do_enq;
         do_deq = deq_v && (model_q.size() == 1);
         do_enq = enq_v && (model_q.size() == 0 || do_deq);
         if (do_deq) void'(model_q.pop_front());
         if (do_enq) model_q.push_back(enq_d);
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      bit full;
      bit exp_rdy;
      full    = (model_q.size() != 0);
      exp_rdy = !full || deq_v;
      chk(nempty == full, tag, "not_empty", W'(nempty), W'(full));
      chk(deq_rdy == full, tag, "deq_ready", W'(deq_rdy), W'(full));
      chk(enq_rdy == exp_rdy, tag, "enq_ready", W'(enq_rdy), W'(exp_rdy));
      if (full)
         chk(first_d == model_q[0], tag, "first_data", first_d, model_q[0]);
   endtask

   // Drive one cycle's inputs on the falling edge, then compare.
   task automatic step(input bit e, input logic [W-1:0] d, input bit q,
                       input bit c, input string tag);
      @(negedge clk);
      enq_v = e; enq_d = d; deq_v = q; clr = c;
      #0.5;
      compare(tag);
   endtask

   initial begin
      #(200000 * 5);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(nempty == 1'b0, "R1", "not_empty", W'(nempty), '0);
      chk(deq_rdy == 1'b0, "R1", "deq_ready", W'(deq_rdy), '0);
      chk(enq_rdy == 1'b1, "R1", "enq_ready", W'(enq_rdy), W'(1));
      rst_n = 1'b1;
      step(0, '0, 0, 0, "R1");

      // R3: dequeue on empty is ignored
      step(0, '0, 1, 0, "R3");
      step(0, '0, 0, 0, "R3");
      // R4: fill, visible next cycle only
      step(1, 32'hA5A5_0001, 0, 0, "R4");
      chk(nempty == 1'b0, "R4", "not_empty same cycle", W'(nempty), '0);
      step(0, '0, 0, 0, "R4");
      chk(first_d == 32'hA5A5_0001, "R4", "first_data", first_d, 32'hA5A5_0001);
      // R2, R8: full, offer without dequeue refused
      step(1, 32'hDEAD_0002, 0, 0, "R8");
      chk(enq_rdy == 1'b0, "R2", "enq_ready full", W'(enq_rdy), '0);
      step(0, '0, 0, 0, "R9");
      chk(first_d == 32'hA5A5_0001, "R8", "first_data kept", first_d, 32'hA5A5_0001);
      // R6: swap on full, old shown now, new next cycle
      step(1, 32'h0000_BEEF, 1, 0, "R6");
      chk(first_d == 32'hA5A5_0001, "R6", "old data in swap cycle", first_d, 32'hA5A5_0001);
      chk(enq_rdy == 1'b1, "R2", "enq_ready with deq", W'(enq_rdy), W'(1));
      step(1, 32'h0000_C0DE, 1, 0, "R6");
      chk(first_d == 32'h0000_BEEF, "R6", "new data next cycle", first_d, 32'h0000_BEEF);
      step(0, '0, 0, 0, "R6");
      chk(first_d == 32'h0000_C0DE, "R6", "second swap", first_d, 32'h0000_C0DE);
      // R5: drain
      step(0, '0, 1, 0, "R5");
      step(0, '0, 0, 0, "R5");
      chk(nempty == 1'b0, "R5", "empty after drain", W'(nempty), '0);
      // R7: clear against enqueue into empty
      step(1, 32'h1234_5678, 0, 1, "R7");
      step(0, '0, 0, 0, "R7");
      chk(nempty == 1'b0, "R7", "clear beats enq", W'(nempty), '0);
      // R7: clear of a full queue, and clear during a swap
      step(1, 32'h0000_0011, 0, 0, "R7");
      step(1, 32'h0000_0022, 1, 1, "R7");
      step(0, '0, 0, 0, "R7");
      chk(nempty == 1'b0, "R7", "clear during swap", W'(nempty), '0);
      step(1, 32'h0000_0033, 0, 0, "R7");
      step(0, '0, 0, 1, "R7");
      step(0, '0, 0, 0, "R7");
      chk(nempty == 1'b0, "R7", "clear full", W'(nempty), '0);

      // R6: sustained recirculation, one item per cycle
      step(1, 32'h0000_0100, 0, 0, "R6");
      for (int i = 1; i <= 20; i++) begin
         step(1, 32'h0000_0100 + W'(i), 1, 0, "R6");
         chk(enq_rdy == 1'b1, "R6", "loop ready", W'(enq_rdy), W'(1));
      end

      // Mixed random traffic, all requirements
      for (int i = 0; i < 3000; i++) begin
         bit e;
         bit q;
         bit c;
         e = ($urandom_range(0, 3) != 0);
         q = ($urandom_range(0, 2) != 0);
         c = ($urandom_range(0, 31) == 0);
         step(e, W'($urandom), q, c, "R9");
      end

      step(0, '0, 0, 0, "R9");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule